// File: doc/BRIEF.md
# In-Order Retirement Tracker with Event Counters

This block is the retirement stage of an out-of-order core. Each instruction is entered at the tail of a circular tracking buffer, together with the number of micro-operations it was split into. It is held there until every one of those micro-operations has reported completion. Completion reports carry the instruction's tag, which is its buffer slot, and may arrive in any order. Up to `CPL_PORTS` reports can arrive in one cycle.

Each cycle the stage looks at the oldest held instructions. It retires the longest run of finished ones starting at the head, capped at three. For each retiring instruction it raises one strobe per retire slot. An unfinished instruction blocks every younger one, even when the younger ones are done.

Two event counters observe the stage. Each one is programmed on its own to count either retired instructions or stall cycles. A read-select input picks which counter appears on the read port.

Allocation is a valid/ready handshake: an instruction is taken on a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` depends only on the buffer occupancy at the start of the cycle, so a retirement in the same cycle does not free a slot until the next cycle. Completion reports, retire strobes and counter controls are plain signals with no back-pressure.

Top module: `retire_unit`

## Requirements
- R1: After reset the buffer is empty: all retire strobes are 0, `alloc_ready` is 1, `alloc_tag` is 0, and both counters read 0.
- R2: Instructions are allocated in order at the tail. `alloc_tag` gives the slot the next instruction receives and advances by one, modulo `DEPTH`, on each accepted allocation. `alloc_ready` is 0 whenever `DEPTH` instructions are held.
- R3: Each completion report whose tag names a held instruction lowers that instruction's outstanding count by one. Two reports for the same tag in one cycle lower it by two. An instruction becomes eligible to retire in the cycle after its last outstanding micro-operation is reported.
- R4: At most three instructions retire per cycle. Retire strobe slot 0 is the oldest instruction, and the strobes form a contiguous run starting at slot 0 (000, 001, 011 or 111).
- R5: Retirement is in strict program order: a finished instruction never retires while an older held instruction is unfinished.
- R6: `retire_tag` slot k (bits k*IDX_W and up) always carries the buffer slot head+k, modulo `DEPTH`.
- R7: Each of the two counters has its own event select in `ev_sel`: bit g at 0 selects instructions retired, at 1 selects stall cycles. `cnt_rd_sel` at 0 shows counter 0 and at 1 shows counter 1.
- R8: The retired-instruction event adds, at the clock edge, the number of strobes raised in that cycle.
- R9: The stall event adds one for each cycle in which at least one instruction is held and none retires. An empty buffer is not counted as a stall.
- R10: Counters are `CNT_W` bits wide and wrap modulo 2^CNT_W. When `ev_clr` bit g is high, counter g reads 0 after the edge, and the clear wins over any increment in that cycle.
- R11: A completion report for a tag that is not held, or one that arrives after the tag's count has already reached zero, changes nothing.
- R12: An instruction allocated with a micro-operation count of zero is finished at once and can retire in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | An instruction is offered for allocation |
| alloc_uops | input | UOP_W | Micro-operation count of the offered instruction |
| alloc_ready | output | 1 | The buffer has a free slot this cycle |
| alloc_tag | output | IDX_W | Slot the offered instruction receives |
| done_valid | input | CPL_PORTS | One bit per completion report port |
| done_tag | input | CPL_PORTS*IDX_W | Tag of each completion report, port p at bits p*IDX_W |
| retire_strobe | output | RET_W | Per-slot retire strobes, slot 0 oldest |
| retire_tag | output | RET_W*IDX_W | Buffer slot presented in each retire slot |
| ev_sel | input | 2 | Event select per counter: 0 retired, 1 stall |
| ev_clr | input | 2 | Clear per counter |
| cnt_rd_sel | input | 1 | Selects which counter drives `cnt_rd_data` |
| cnt_rd_data | output | CNT_W | Value of the selected counter |

## Verification
A wrong outstanding count or held flag shows on the same cycle it matters. An instruction retires one cycle early or late, or it blocks the head forever, and the retire strobes then disagree with an arithmetic model of the buffer from that cycle onward. A slipped head or tail pointer shows at once on `retire_tag` or `alloc_tag`. A counter fault (a wrong increment, a clear that loses to an increment, or stalls counted while the buffer is empty) appears on `cnt_rd_data` in the next cycle the bench reads that counter. A narrow-counter instance makes wraparound visible within a few dozen cycles.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

  typedef enum logic {
    EV_RETIRED = 1'b0,
    EV_STALL   = 1'b1
  } rtr_event_e;

endpackage

// File: rtl/rtr_entry_table.sv
module rtr_entry_table #(
  parameter int DEPTH     = 8,
  parameter int UOP_W     = 3,
  parameter int CPL_PORTS = 2,
  parameter int RET_W     = 3,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int OCC_W    = $clog2(DEPTH + 1),
  localparam int CNT_RW   = $clog2(RET_W + 1),
  localparam int HIT_W    = $clog2(CPL_PORTS + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               alloc_fire,
  input  logic [UOP_W-1:0]                   alloc_uops,
  input  logic [CPL_PORTS-1:0]               done_valid,
  input  logic [CPL_PORTS-1:0][IDX_W-1:0]    done_tag,
  input  logic [CNT_RW-1:0]                  retire_cnt,
  output logic [IDX_W-1:0]                   head,
  output logic [IDX_W-1:0]                   tail,
  output logic [OCC_W-1:0]                   occ,
  output logic [DEPTH-1:0]                   done_mask
);

  logic [IDX_W-1:0] head_q, tail_q;
  logic [OCC_W-1:0] occ_q;
  logic [DEPTH-1:0] held_q;
  logic [UOP_W-1:0] rem_q [DEPTH];
  logic [HIT_W-1:0] hits [DEPTH];
  logic [DEPTH-1:0] ret_mask;

  // completion reports landing on each slot this cycle
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hits[i] = '0;
      for (int p = 0; p < CPL_PORTS; p++) begin
        hits[i] = hits[i] + HIT_W'(done_valid[p] && (done_tag[p] == IDX_W'(i)));
      end
    end
  end

  // slots leaving the buffer this cycle
  always_comb begin
    ret_mask = '0;
    for (int k = 0; k < RET_W; k++) begin
      if (CNT_RW'(k) < retire_cnt) begin
        ret_mask[IDX_W'(head_q + IDX_W'(k))] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held_q[i] <= 1'b0;
        rem_q[i]  <= '0;
      end else if (alloc_fire && (tail_q == IDX_W'(i))) begin
        held_q[i] <= 1'b1;
        rem_q[i]  <= alloc_uops;
      end else begin
        if (ret_mask[i]) begin
          held_q[i] <= 1'b0;
        end
        if (held_q[i] && (hits[i] != '0)) begin
          if (int'(hits[i]) >= int'(rem_q[i])) begin
            rem_q[i] <= '0;
          end else begin
            rem_q[i] <= rem_q[i] - UOP_W'(hits[i]);
          end
        end
      end
    end

    assign done_mask[i] = held_q[i] && (rem_q[i] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= head_q + IDX_W'(retire_cnt);
      tail_q <= tail_q + IDX_W'(alloc_fire);
      occ_q  <= occ_q + OCC_W'(alloc_fire) - OCC_W'(retire_cnt);
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign occ  = occ_q;

endmodule

// File: rtl/rtr_retire_sel.sv
module rtr_retire_sel #(
  parameter int DEPTH  = 8,
  parameter int RET_W  = 3,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int OCC_W  = $clog2(DEPTH + 1),
  localparam int CNT_RW = $clog2(RET_W + 1)
) (
  input  logic [IDX_W-1:0]             head,
  input  logic [OCC_W-1:0]             occ,
  input  logic [DEPTH-1:0]             done_mask,
  output logic [RET_W-1:0]             strobe,
  output logic [RET_W-1:0][IDX_W-1:0]  slot_tag,
  output logic [CNT_RW-1:0]            retire_cnt
);

  logic             run;
  logic [IDX_W-1:0] idx;

  // oldest-first scan; the first unfinished slot ends the run
  always_comb begin
    run        = 1'b1;
    retire_cnt = '0;
    idx        = head;
    for (int k = 0; k < RET_W; k++) begin
      idx         = head + IDX_W'(k);
      slot_tag[k] = idx;
      strobe[k]   = run && (k < int'(occ)) && done_mask[idx];
      run         = strobe[k];
      retire_cnt  = retire_cnt + CNT_RW'(strobe[k]);
    end
  end

endmodule

// File: rtl/rtr_evt_counter.sv
module rtr_evt_counter
  import rtr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int CNT_RW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  rtr_event_e        sel,
  input  logic [CNT_RW-1:0] retire_cnt,
  input  logic              busy,
  output logic [CNT_W-1:0]  value
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] inc;

  always_comb begin
    if (sel == EV_RETIRED) begin
      inc = CNT_W'(retire_cnt);
    end else begin
      inc = CNT_W'(busy && (retire_cnt == '0));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + inc;
    end
  end

  assign value = cnt_q;

endmodule

// File: rtl/retire_unit.sv
module retire_unit
  import rtr_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int UOP_W     = 3,
  parameter int CPL_PORTS = 2,
  parameter int RET_W     = 3,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int OCC_W    = $clog2(DEPTH + 1),
  localparam int CNT_RW   = $clog2(RET_W + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_valid,
  input  logic [UOP_W-1:0]           alloc_uops,
  output logic                       alloc_ready,
  output logic [IDX_W-1:0]           alloc_tag,
  input  logic [CPL_PORTS-1:0]       done_valid,
  input  logic [CPL_PORTS*IDX_W-1:0] done_tag,
  output logic [RET_W-1:0]           retire_strobe,
  output logic [RET_W*IDX_W-1:0]     retire_tag,
  input  logic [1:0]                 ev_sel,
  input  logic [1:0]                 ev_clr,
  input  logic                       cnt_rd_sel,
  output logic [CNT_W-1:0]           cnt_rd_data
);

  logic [CPL_PORTS-1:0][IDX_W-1:0] done_tag_a;
  logic [RET_W-1:0][IDX_W-1:0]     slot_tag;
  logic [IDX_W-1:0]                head, tail;
  logic [OCC_W-1:0]                occ;
  logic [DEPTH-1:0]                done_mask;
  logic [CNT_RW-1:0]               retire_cnt;
  logic                            alloc_fire;
  logic [1:0][CNT_W-1:0]           ev_cnt;

  assign done_tag_a  = done_tag;
  assign alloc_ready = (int'(occ) < DEPTH);
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;
  assign retire_tag  = slot_tag;

  rtr_entry_table #(
    .DEPTH(DEPTH), .UOP_W(UOP_W), .CPL_PORTS(CPL_PORTS), .RET_W(RET_W)
  ) table_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .alloc_uops (alloc_uops),
    .done_valid (done_valid),
    .done_tag   (done_tag_a),
    .retire_cnt (retire_cnt),
    .head       (head),
    .tail       (tail),
    .occ        (occ),
    .done_mask  (done_mask)
  );

  rtr_retire_sel #(
    .DEPTH(DEPTH), .RET_W(RET_W)
  ) sel_i (
    .head       (head),
    .occ        (occ),
    .done_mask  (done_mask),
    .strobe     (retire_strobe),
    .slot_tag   (slot_tag),
    .retire_cnt (retire_cnt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ev
    rtr_evt_counter #(
      .CNT_W(CNT_W), .CNT_RW(CNT_RW)
    ) ctr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (ev_clr[g]),
      .sel        (rtr_event_e'(ev_sel[g])),
      .retire_cnt (retire_cnt),
      .busy       (occ != '0),
      .value      (ev_cnt[g])
    );
  end

  assign cnt_rd_data = ev_cnt[cnt_rd_sel];

endmodule

// File: rtl/rtr_retire_chk.sv
module rtr_retire_chk #(
  parameter int DEPTH = 8,
  parameter int RET_W = 3,
  parameter int CNT_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  alloc_valid,
  input logic                  alloc_ready,
  input logic [IDX_W-1:0]      alloc_tag,
  input logic [RET_W-1:0]      retire_strobe,
  input logic [1:0]            ev_sel,
  input logic [1:0]            ev_clr,
  input logic [OCC_W-1:0]      occ,
  input logic [1:0][CNT_W-1:0] ev_cnt
);

  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> (retire_strobe == '0) && alloc_ready);

  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ) == DEPTH) |-> !alloc_ready);

  a_r2_tag_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_tag == IDX_W'($past(alloc_tag) + 1'b1)));

  a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    retire_strobe == RET_W'((1 << $countones(retire_strobe)) - 1));

  for (genvar g = 0; g < 2; g++) begin : g_ev
    a_r8_retired_adds: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_clr[g] && !ev_sel[g])
      |=> ev_cnt[g] == CNT_W'($past(ev_cnt[g]) + CNT_W'($past($countones(retire_strobe)))));

    a_r9_stall_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_clr[g] && ev_sel[g])
      |=> ev_cnt[g] == CNT_W'($past(ev_cnt[g])
                              + CNT_W'($past(occ != '0 && retire_strobe == '0))));

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ev_clr[g] |=> (ev_cnt[g] == '0));
  end

endmodule

bind retire_unit rtr_retire_chk #(
  .DEPTH(DEPTH), .RET_W(RET_W), .CNT_W(CNT_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_valid   (alloc_valid),
  .alloc_ready   (alloc_ready),
  .alloc_tag     (alloc_tag),
  .retire_strobe (retire_strobe),
  .ev_sel        (ev_sel),
  .ev_clr        (ev_clr),
  .occ           (occ),
  .ev_cnt        (ev_cnt)
);

// File: tb/retire_unit_tb_top.sv
module retire_unit_tb_top;

  localparam int D = 8;
  localparam int IW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_valid = 1'b0;
  logic [2:0]  a_uops = '0;
  logic        a_ready, a_ready_w;
  logic [2:0]  a_tag, a_tag_w;
  logic [1:0]  d_valid = '0;
  logic [5:0]  d_tag = '0;
  logic [2:0]  r_strobe, r_strobe_w;
  logic [8:0]  r_tag, r_tag_w;
  logic [1:0]  ev_sel = '0;
  logic [1:0]  ev_clr = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic [3:0]  rd_data_w;

  always #5 clk = ~clk;

  retire_unit dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(a_valid), .alloc_uops(a_uops),
    .alloc_ready(a_ready), .alloc_tag(a_tag), .done_valid(d_valid), .done_tag(d_tag),
    .retire_strobe(r_strobe), .retire_tag(r_tag), .ev_sel(ev_sel), .ev_clr(ev_clr),
    .cnt_rd_sel(rd_sel), .cnt_rd_data(rd_data)
  );

  // narrow counters so that wraparound is reachable (R10)
  retire_unit #(.CNT_W(4)) dut_w (
    .clk(clk), .rst_n(rst_n), .alloc_valid(a_valid), .alloc_uops(a_uops),
    .alloc_ready(a_ready_w), .alloc_tag(a_tag_w), .done_valid(d_valid), .done_tag(d_tag),
    .retire_strobe(r_strobe_w), .retire_tag(r_tag_w), .ev_sel(ev_sel), .ev_clr(ev_clr),
    .cnt_rd_sel(rd_sel), .cnt_rd_data(rd_data_w)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  int          m_rem [D];
  bit          m_held [D];
  int          m_head = 0, m_tail = 0, m_occ = 0;
  logic [31:0] m_ctr [2];
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // one cycle: inputs already driven just after the edge; compare mid-cycle, then advance the model
  task automatic step();
    int   nret = 0;
    bit   run = 1'b1;
    bit   busy;
    bit   fire;
    logic [2:0] es = '0;
    #4;
    for (int k = 0; k < 3; k++) begin
      int idx = (m_head + k) % D;
      if (run && k < m_occ && m_held[idx] && m_rem[idx] == 0) begin
        es[k] = 1'b1;
        nret++;
      end else begin
        run = 1'b0;
      end
    end
    chk("R3 R4 R5 R11 R12", "retire strobes", r_strobe, es);
    for (int k = 0; k < 3; k++) chk("R6", "retire tag", r_tag[k*IW +: IW], (m_head + k) % D);
    chk("R2", "alloc ready", a_ready, (m_occ < D));
    chk("R2", "alloc tag", a_tag, m_tail);
    chk("R7 R8 R9", "counter read", rd_data, m_ctr[rd_sel]);
    chk("R10", "narrow counter", rd_data_w, m_ctr[rd_sel] & 32'hF);
    fire = a_valid && (m_occ < D);
    busy = (m_occ > 0);
    for (int p = 0; p < 2; p++) begin
      int t = d_tag[p*IW +: IW];
      if (d_valid[p] && m_held[t] && m_rem[t] > 0) m_rem[t]--;
    end
    for (int k = 0; k < nret; k++) m_held[(m_head + k) % D] = 1'b0;
    m_head = (m_head + nret) % D;
    m_occ  = m_occ - nret;
    if (fire) begin
      m_held[m_tail] = 1'b1;
      m_rem[m_tail]  = a_uops;
      m_tail = (m_tail + 1) % D;
      m_occ++;
    end
    for (int g = 0; g < 2; g++) begin
      if (ev_clr[g]) m_ctr[g] = '0;
      else if (!ev_sel[g]) m_ctr[g] = m_ctr[g] + nret;
      else if (busy && nret == 0) m_ctr[g] = m_ctr[g] + 1;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    a_valid = 1'b0;
    d_valid = '0;
    ev_clr  = '0;
  endtask

  initial begin
    for (int i = 0; i < D; i++) begin
      m_rem[i] = 0;
      m_held[i] = 1'b0;
    end
    m_ctr[0] = '0;
    m_ctr[1] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #4;
    // R1: reset state
    chk("R1", "strobes after reset", r_strobe, 0);
    chk("R1", "ready after reset", a_ready, 1);
    chk("R1", "tag after reset", a_tag, 0);
    chk("R1", "counter 0 after reset", rd_data, 0);
    @(posedge clk);
    #1;

    // R9: empty buffer never counts as a stall
    ev_sel = 2'b10;
    rd_sel = 1'b1;
    repeat (4) step();
    #4;
    chk("R9", "stall count while empty", rd_data, 0);
    @(posedge clk);
    #1;
    m_ctr[0] = m_ctr[0];

    // R11: a report for an unheld tag is dropped
    d_valid = 2'b01;
    d_tag   = 6'd0;
    step();
    quiet();

    // R2: fill the buffer, then offer one more
    for (int i = 0; i < D; i++) begin
      a_valid = 1'b1;
      a_uops  = 3'((i % 3) + 1);
      step();
    end
    a_uops = 3'd1;
    step();
    quiet();

    // R5: finish youngest first; nothing may leave until the head is done
    for (int t = D - 1; t >= 0; t--) begin
      d_valid = 2'b11;
      d_tag   = {3'(t), 3'(t)};
      step();
      d_valid = 2'b01;
      step();
      quiet();
      if (t > 0) begin
        #4;
        chk("R5", "no retire behind unfinished head", r_strobe, 0);
        @(posedge clk);
        #1;
        m_ctr[1] = m_ctr[1] + ((m_occ > 0) ? 1 : 0);
        if (!ev_sel[0]) m_ctr[0] = m_ctr[0];
      end
    end
    // R4: drain at three per cycle
    repeat (5) step();

    // R12: zero micro-operation instructions retire without reports
    rd_sel = 1'b0;
    for (int i = 0; i < 5; i++) begin
      a_valid = 1'b1;
      a_uops  = 3'd0;
      step();
    end
    quiet();
    repeat (3) step();

    // R10: clear both counters
    ev_clr = 2'b11;
    step();
    quiet();
    step();

    // mixed sweep
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = rnd();
      a_valid = r[0] | r[1];
      a_uops  = 3'(r[3:2]);
      d_valid = r[5:4];
      d_tag   = r[11:6];
      rd_sel  = r[12];
      ev_clr  = (r[20:14] == 0) ? r[22:21] : 2'b00;
      if (n % 500 == 0) ev_sel = 2'(n / 500);
      step();
    end
    quiet();
    repeat (10) step();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule